// File: doc/BRIEF.md
# Exclusive Dual Private Cache Controller

This block manages two private tag directories that sit side by side at the same level. Both use one block size, but each has its own number of sets and ways. Every access names a requester (0 or 1). That requester's directory is the local cache and the other one is the peer. The controller probes the local directory first. On a local hit it only refreshes recency. On a local miss it looks at the peer. If the peer holds the block, the block is taken out of the peer and filled into the local directory, so the two directories never hold the same block at the same time. The block carries no data: memory traffic and write-back belong to other logic.

Requests are accepted one at a time on a valid/ready handshake. For each phase of work, the controller emits a one-cycle result pulse. The result gives the local outcome, the block-aligned victim and fill addresses, and whether the block was migrated from the peer together with its block address. A modify request runs as a load phase followed by a store phase, and each phase goes through the full local-then-peer sequence. Each cache keeps hit, miss and eviction counters. A sticky error flag reports a block found valid in both directories after an access.

Top module: `xpair_ctrl`

## Requirements
- R1: `req_port` = 0 makes the first directory (P1) local and the second (P2) the peer; `req_port` = 1 reverses this. `rsp_port` echoes the local side, and `rsp_addr` echoes the request address.
- R2: On a local hit the status is 1 (hit) and the local hit counter increments. The peer is not used: `rsp_peer_hit` is 0 and the peer's counters do not change.
- R3: On a local miss the block is filled locally and the local miss counter increments. Status 0 (fill into a free way) gives `rsp_insert_addr` as the block-aligned address and `rsp_victim_addr` as 0.
- R4: On a local miss where the peer holds the block, the peer's hit counter increments, the block is removed from the peer and filled locally, and `rsp_peer_hit` is 1 with `rsp_mig_addr` equal to the block address. A later access from the peer side to that block misses locally and migrates it back.
- R5: When a fill has no free way, the status is 2 (fill with eviction), `rsp_victim_addr` gives the evicted block and the local eviction counter increments. The evicted block is dropped: it does not appear in the peer.
- R6: A fill uses the lowest-numbered invalid way of the set first. When the set is full, the least recently used valid way is replaced, where both hits and fills count as uses.
- R7: `req_op` is encoded as 0 = load, 1 = store, 2 = modify (3 acts as a load). Load and store each produce one result, with `rsp_store` = 0 and 1 respectively. Modify produces two results in order: a load phase (`rsp_store` = 0), then a store phase (`rsp_store` = 1) to the same address.
- R8: `excl_err` rises if, after an access completes, any block is valid in both directories. Once set, it stays set until reset. In correct operation it stays 0.
- R9: After reset all counters are 0, `req_ready` is 1, and `rsp_valid` and `excl_err` are 0.
- R10: `req_ready` is high only while idle. Each phase produces exactly one single-cycle `rsp_valid` pulse, and no pulse occurs while `req_ready` is high.
- R11: With 4 sets, 1 way and 16-byte blocks on both sides, the sequence P1 load 0x1000, P2 load 0x1200, P1 load 0x1202, P2 load 0x1002, P1 load 0x2000 ends with P1 at 0 hits, 3 misses, 2 evictions and P2 at 1 hit, 2 misses, 0 evictions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_port | input | 1 | Requester: 0 = P1 local, 1 = P2 local |
| req_op | input | 2 | 0 load, 1 store, 2 modify |
| req_addr | input | ADDR_W | Byte address |
| rsp_valid | output | 1 | One-cycle result pulse per phase |
| rsp_port | output | 1 | Local side of this result |
| rsp_store | output | 1 | 1 for a store phase |
| rsp_addr | output | ADDR_W | Request address |
| rsp_status | output | 2 | 0 fill, 1 hit, 2 fill with eviction |
| rsp_victim_addr | output | ADDR_W | Evicted block address (0 if none) |
| rsp_insert_addr | output | ADDR_W | Filled block address (0 on hit) |
| rsp_peer_hit | output | 1 | Block migrated from peer |
| rsp_mig_addr | output | ADDR_W | Migrated block address (0 if none) |
| p1_hits | output | CNT_W | P1 hit count |
| p1_misses | output | CNT_W | P1 miss count |
| p1_evicts | output | CNT_W | P1 eviction count |
| p2_hits | output | CNT_W | P2 hit count |
| p2_misses | output | CNT_W | P2 miss count |
| p2_evicts | output | CNT_W | P2 eviction count |
| excl_err | output | 1 | Sticky exclusivity violation |

## Verification
The bench builds two copies.

- **Direct-mapped copy:** 4 sets and 1 way on each side with 16-byte blocks. It runs the five-access migration sequence, the local-hit case and the migrate-back case, where every fill into an occupied set must evict.
- **Uneven copy:** P1 has 2 sets by 4 ways and P2 has 4 sets by 2 ways. It brings within reach the invalid-way-first rule, true LRU ordering after a hit reorders the set, and a modify whose load phase migrates from a peer with a different geometry.

// File: rtl/xpair_pkg.sv
package xpair_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_MODIFY = 2'd2
  } xp_op_e;

  typedef enum logic [1:0] {
    RES_FILL  = 2'd0,
    RES_HIT   = 2'd1,
    RES_EVICT = 2'd2
  } xp_res_e;

  typedef enum logic [1:0] {
    FSM_IDLE  = 2'd0,
    FSM_PHASE = 2'd1,
    FSM_CHECK = 2'd2
  } xp_fsm_e;

endpackage

// File: rtl/xpair_dir.sv
module xpair_dir #(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 4,
  parameter int SET_BITS = 2,
  parameter int WAYS     = 2,
  localparam int BLK_W   = ADDR_W - OFF_BITS,
  localparam int SETS    = 1 << SET_BITS,
  localparam int LINES   = SETS * WAYS,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BLK_W-1:0]       lk_blk,
  output logic                   lk_hit,
  output logic                   set_full,
  output logic [BLK_W-1:0]       vic_blk,
  input  logic                   do_touch,
  input  logic                   do_fill,
  input  logic                   do_drop,
  output logic [LINES-1:0]       line_valid,
  output logic [LINES*BLK_W-1:0] line_blk
);
  localparam int TAG_W = BLK_W - SET_BITS;

  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  valid_d [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAY_W-1:0] age_q   [SETS][WAYS];
  logic [WAY_W-1:0] age_d   [SETS][WAYS];

  logic [SET_BITS-1:0] lk_set;
  logic [TAG_W-1:0]    lk_tag;
  logic [WAYS-1:0]     hit_vec;
  logic [WAY_W-1:0]    hit_way;
  logic [WAY_W-1:0]    fill_way;
  logic [WAY_W-1:0]    use_way;
  logic                found_free;

  assign lk_set = lk_blk[SET_BITS-1:0];
  assign lk_tag = lk_blk[BLK_W-1:SET_BITS];

  // lookup in the addressed set
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
  assign lk_hit   = |hit_vec;
  assign set_full = &valid_q[lk_set];

  // placement: lowest free way, else the oldest way
  always_comb begin
    fill_way   = '0;
    found_free = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_q[lk_set][w] && !found_free) begin
        fill_way   = WAY_W'(w);
        found_free = 1'b1;
      end
    end
    if (!found_free) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[lk_set][w] == WAY_W'(WAYS - 1)) fill_way = WAY_W'(w);
      end
    end
  end
  assign vic_blk = {tag_q[lk_set][fill_way], lk_set};
  assign use_way = do_fill ? fill_way : hit_way;

  // next state of valid bits and recency ranks
  always_comb begin
    valid_d = valid_q;
    age_d   = age_q;
    if (do_touch || do_fill) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == use_way) begin
          age_d[lk_set][w] = '0;
        end else if (age_q[lk_set][w] < age_q[lk_set][use_way]) begin
          age_d[lk_set][w] = age_q[lk_set][w] + WAY_W'(1);
        end
      end
    end
    if (do_fill) valid_d[lk_set][fill_way] = 1'b1;
    if (do_drop) valid_d[lk_set][hit_way]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      valid_q <= valid_d;
      age_q   <= age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) tag_q[lk_set][fill_way] <= lk_tag;
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign line_valid[s*WAYS+w]          = valid_q[s][w];
      assign line_blk[(s*WAYS+w)*BLK_W +: BLK_W] = {tag_q[s][w], SET_BITS'(s)};
    end
  end

  p_hit_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  p_fill_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    do_fill |-> !lk_hit);
  p_drop_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_drop |-> lk_hit);
  p_fill_marks_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_fill |=> lk_hit || $changed(lk_blk));

endmodule

// File: rtl/xpair_dupchk.sv
module xpair_dupchk #(
  parameter int BLK_W = 28,
  parameter int N1    = 8,
  parameter int N2    = 8
) (
  input  logic [N1-1:0]       v1,
  input  logic [N1*BLK_W-1:0] b1,
  input  logic [N2-1:0]       v2,
  input  logic [N2*BLK_W-1:0] b2,
  output logic                dup
);
  logic [N1*N2-1:0] pair_hit;

  for (genvar i = 0; i < N1; i++) begin : g_a
    for (genvar j = 0; j < N2; j++) begin : g_b
      assign pair_hit[i*N2+j] = v1[i] && v2[j] &&
        (b1[i*BLK_W +: BLK_W] == b2[j*BLK_W +: BLK_W]);
    end
  end
  assign dup = |pair_hit;

endmodule

// File: rtl/xpair_stats.sv
module xpair_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_hit,
  input  logic             inc_miss,
  input  logic             inc_evict,
  output logic [CNT_W-1:0] hits,
  output logic [CNT_W-1:0] misses,
  output logic [CNT_W-1:0] evicts
);
  logic [CNT_W-1:0] hits_d, misses_d, evicts_d;

  always_comb begin
    hits_d   = hits   + CNT_W'(inc_hit);
    misses_d = misses + CNT_W'(inc_miss);
    evicts_d = evicts + CNT_W'(inc_evict);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits   <= '0;
      misses <= '0;
      evicts <= '0;
    end else begin
      hits   <= hits_d;
      misses <= misses_d;
      evicts <= evicts_d;
    end
  end

  p_evict_is_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evict |-> inc_miss);

endmodule

// File: rtl/xpair_ctrl.sv
module xpair_ctrl
  import xpair_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFF_BITS    = 4,
  parameter int P1_SET_BITS = 2,
  parameter int P1_WAYS     = 2,
  parameter int P2_SET_BITS = 2,
  parameter int P2_WAYS     = 2,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_port,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_port,
  output logic              rsp_store,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [1:0]        rsp_status,
  output logic [ADDR_W-1:0] rsp_victim_addr,
  output logic [ADDR_W-1:0] rsp_insert_addr,
  output logic              rsp_peer_hit,
  output logic [ADDR_W-1:0] rsp_mig_addr,
  output logic [CNT_W-1:0]  p1_hits,
  output logic [CNT_W-1:0]  p1_misses,
  output logic [CNT_W-1:0]  p1_evicts,
  output logic [CNT_W-1:0]  p2_hits,
  output logic [CNT_W-1:0]  p2_misses,
  output logic [CNT_W-1:0]  p2_evicts,
  output logic              excl_err
);
  localparam int BLK_W  = ADDR_W - OFF_BITS;
  localparam int LINES1 = (1 << P1_SET_BITS) * P1_WAYS;
  localparam int LINES2 = (1 << P2_SET_BITS) * P2_WAYS;

  xp_fsm_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              port_q, port_d;
  logic              store_q, store_d;
  logic              more_q, more_d;
  logic              err_q, err_d;

  logic              in_phase;
  logic [BLK_W-1:0]  cur_blk;
  logic [ADDR_W-1:0] cur_blk_addr;

  logic              d1_hit, d1_full, d2_hit, d2_full;
  logic [BLK_W-1:0]  d1_vic, d2_vic;
  logic [LINES1-1:0]       d1_lv;
  logic [LINES1*BLK_W-1:0] d1_lb;
  logic [LINES2-1:0]       d2_lv;
  logic [LINES2*BLK_W-1:0] d2_lb;
  logic              dup;

  logic              loc_hit, peer_has, loc_full;
  logic [BLK_W-1:0]  loc_vic;
  logic [1:0]        inc_hit, inc_miss, inc_evict;
  logic [CNT_W-1:0]  hit_cnt [2];
  logic [CNT_W-1:0]  miss_cnt [2];

  assign in_phase     = (st_q == FSM_PHASE);
  assign cur_blk      = addr_q[ADDR_W-1:OFF_BITS];
  assign cur_blk_addr = {cur_blk, {OFF_BITS{1'b0}}};

  // local and peer views of the two directories
  assign loc_hit  = port_q ? d2_hit  : d1_hit;
  assign peer_has = port_q ? d1_hit  : d2_hit;
  assign loc_full = port_q ? d2_full : d1_full;
  assign loc_vic  = port_q ? d2_vic  : d1_vic;

  xpair_dir #(
    .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS),
    .SET_BITS(P1_SET_BITS), .WAYS(P1_WAYS)
  ) u_dir1 (
    .clk(clk), .rst_n(rst_n), .lk_blk(cur_blk),
    .lk_hit(d1_hit), .set_full(d1_full), .vic_blk(d1_vic),
    .do_touch(in_phase && !port_q && d1_hit),
    .do_fill (in_phase && !port_q && !d1_hit),
    .do_drop (in_phase &&  port_q && !d2_hit && d1_hit),
    .line_valid(d1_lv), .line_blk(d1_lb)
  );

  xpair_dir #(
    .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS),
    .SET_BITS(P2_SET_BITS), .WAYS(P2_WAYS)
  ) u_dir2 (
    .clk(clk), .rst_n(rst_n), .lk_blk(cur_blk),
    .lk_hit(d2_hit), .set_full(d2_full), .vic_blk(d2_vic),
    .do_touch(in_phase &&  port_q && d2_hit),
    .do_fill (in_phase &&  port_q && !d2_hit),
    .do_drop (in_phase && !port_q && !d1_hit && d2_hit),
    .line_valid(d2_lv), .line_blk(d2_lb)
  );

  xpair_dupchk #(.BLK_W(BLK_W), .N1(LINES1), .N2(LINES2)) u_dup (
    .v1(d1_lv), .b1(d1_lb), .v2(d2_lv), .b2(d2_lb), .dup(dup)
  );

  for (genvar g = 0; g < 2; g++) begin : g_stat
    assign inc_hit[g]   = in_phase && ((port_q == 1'(g)) ? loc_hit
                                                         : (!loc_hit && peer_has));
    assign inc_miss[g]  = in_phase && (port_q == 1'(g)) && !loc_hit;
    assign inc_evict[g] = in_phase && (port_q == 1'(g)) && !loc_hit && loc_full;
  end

  xpair_stats #(.CNT_W(CNT_W)) u_st1 (
    .clk(clk), .rst_n(rst_n),
    .inc_hit(inc_hit[0]), .inc_miss(inc_miss[0]), .inc_evict(inc_evict[0]),
    .hits(p1_hits), .misses(p1_misses), .evicts(p1_evicts)
  );
  xpair_stats #(.CNT_W(CNT_W)) u_st2 (
    .clk(clk), .rst_n(rst_n),
    .inc_hit(inc_hit[1]), .inc_miss(inc_miss[1]), .inc_evict(inc_evict[1]),
    .hits(p2_hits), .misses(p2_misses), .evicts(p2_evicts)
  );
  assign hit_cnt[0]  = p1_hits;
  assign hit_cnt[1]  = p2_hits;
  assign miss_cnt[0] = p1_misses;
  assign miss_cnt[1] = p2_misses;

  // sequencing: accept, one or two phases, exclusivity check
  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    port_d  = port_q;
    store_d = store_q;
    more_d  = more_q;
    err_d   = err_q;
    unique case (st_q)
      FSM_IDLE: begin
        if (req_valid) begin
          st_d    = FSM_PHASE;
          addr_d  = req_addr;
          port_d  = req_port;
          store_d = (req_op == OP_STORE);
          more_d  = (req_op == OP_MODIFY);
        end
      end
      FSM_PHASE: begin
        if (more_q) begin
          store_d = 1'b1;
          more_d  = 1'b0;
        end else begin
          st_d = FSM_CHECK;
        end
      end
      FSM_CHECK: begin
        err_d = err_q || dup;
        st_d  = FSM_IDLE;
      end
      default: st_d = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= FSM_IDLE;
      err_q     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      err_q     <= err_d;
      rsp_valid <= in_phase;
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr_d;
    port_q  <= port_d;
    store_q <= store_d;
    more_q  <= more_d;
  end

  // result fields, loaded once per phase
  always_ff @(posedge clk) begin
    if (in_phase) begin
      rsp_port        <= port_q;
      rsp_store       <= store_q;
      rsp_addr        <= addr_q;
      rsp_status      <= loc_hit ? RES_HIT : (loc_full ? RES_EVICT : RES_FILL);
      rsp_victim_addr <= (!loc_hit && loc_full) ? {loc_vic, {OFF_BITS{1'b0}}} : '0;
      rsp_insert_addr <= loc_hit ? '0 : cur_blk_addr;
      rsp_peer_hit    <= !loc_hit && peer_has;
      rsp_mig_addr    <= (!loc_hit && peer_has) ? cur_blk_addr : '0;
    end
  end

  assign req_ready = (st_q == FSM_IDLE);
  assign excl_err  = err_q;

  p_excl_after_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FSM_CHECK) |-> !dup);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    excl_err |=> excl_err);
  p_no_pulse_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);
  p_hit_no_peer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == RES_HIT) |-> !rsp_peer_hit);

  for (genvar g = 0; g < 2; g++) begin : g_chk
    p_miss_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_port == 1'(g) && rsp_status != RES_HIT) |->
        miss_cnt[g] == $past(miss_cnt[g]) + CNT_W'(1));
    p_peer_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_port != 1'(g) && rsp_peer_hit) |->
        hit_cnt[g] == $past(hit_cnt[g]) + CNT_W'(1));
  end

endmodule

// File: tb/xpair_ctrl_test.sv
module xpair_ctrl_test;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          sel = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_port = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;

  logic          a_rdy, a_rv, a_rp, a_rs, a_ph, a_err;
  logic [1:0]    a_st;
  logic [AW-1:0] a_ad, a_vic, a_ins, a_mig;
  logic [CW-1:0] a_c [6];
  logic          w_rdy, w_rv, w_rp, w_rs, w_ph, w_err;
  logic [1:0]    w_st;
  logic [AW-1:0] w_ad, w_vic, w_ins, w_mig;
  logic [CW-1:0] w_c [6];

  xpair_ctrl #(.ADDR_W(AW), .OFF_BITS(4), .P1_SET_BITS(2), .P1_WAYS(1),
               .P2_SET_BITS(2), .P2_WAYS(1), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && !sel), .req_ready(a_rdy),
    .req_port(req_port), .req_op(req_op), .req_addr(req_addr),
    .rsp_valid(a_rv), .rsp_port(a_rp), .rsp_store(a_rs), .rsp_addr(a_ad),
    .rsp_status(a_st), .rsp_victim_addr(a_vic), .rsp_insert_addr(a_ins),
    .rsp_peer_hit(a_ph), .rsp_mig_addr(a_mig),
    .p1_hits(a_c[0]), .p1_misses(a_c[1]), .p1_evicts(a_c[2]),
    .p2_hits(a_c[3]), .p2_misses(a_c[4]), .p2_evicts(a_c[5]), .excl_err(a_err));

  xpair_ctrl #(.ADDR_W(AW), .OFF_BITS(4), .P1_SET_BITS(1), .P1_WAYS(4),
               .P2_SET_BITS(2), .P2_WAYS(2), .CNT_W(CW)) uut_w (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && sel), .req_ready(w_rdy),
    .req_port(req_port), .req_op(req_op), .req_addr(req_addr),
    .rsp_valid(w_rv), .rsp_port(w_rp), .rsp_store(w_rs), .rsp_addr(w_ad),
    .rsp_status(w_st), .rsp_victim_addr(w_vic), .rsp_insert_addr(w_ins),
    .rsp_peer_hit(w_ph), .rsp_mig_addr(w_mig),
    .p1_hits(w_c[0]), .p1_misses(w_c[1]), .p1_evicts(w_c[2]),
    .p2_hits(w_c[3]), .p2_misses(w_c[4]), .p2_evicts(w_c[5]), .excl_err(w_err));

  wire          b_rdy = sel ? w_rdy : a_rdy;
  wire          b_rv  = sel ? w_rv  : a_rv;
  wire          b_rp  = sel ? w_rp  : a_rp;
  wire          b_rs  = sel ? w_rs  : a_rs;
  wire          b_ph  = sel ? w_ph  : a_ph;
  wire          b_err = sel ? w_err : a_err;
  wire [1:0]    b_st  = sel ? w_st  : a_st;
  wire [AW-1:0] b_ad  = sel ? w_ad  : a_ad;
  wire [AW-1:0] b_vic = sel ? w_vic : a_vic;
  wire [AW-1:0] b_ins = sel ? w_ins : a_ins;
  wire [AW-1:0] b_mig = sel ? w_mig : a_mig;

  int n_chk = 0;
  int n_fail = 0;
  int nrsp;
  logic          r_port [2], r_store [2], r_ph [2];
  logic [1:0]    r_st [2];
  logic [AW-1:0] r_ad [2], r_vic [2], r_ins [2], r_mig [2];

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic counts(input string tag, input int h1, m1, e1, h2, m2, e2);
    chk({tag, " p1 hits"},   sel ? w_c[0] : a_c[0], 64'(h1));
    chk({tag, " p1 misses"}, sel ? w_c[1] : a_c[1], 64'(m1));
    chk({tag, " p1 evicts"}, sel ? w_c[2] : a_c[2], 64'(e1));
    chk({tag, " p2 hits"},   sel ? w_c[3] : a_c[3], 64'(h2));
    chk({tag, " p2 misses"}, sel ? w_c[4] : a_c[4], 64'(m2));
    chk({tag, " p2 evicts"}, sel ? w_c[5] : a_c[5], 64'(e2));
  endtask

  task automatic do_reset(input logic which);
    @(negedge clk);
    sel = which;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one request; collects the result pulses (R10 handshake checked here)
  task automatic access(input logic port, input logic [1:0] op, input logic [AW-1:0] addr,
                        input int nexp);
    @(negedge clk);
    while (!b_rdy) @(negedge clk);
    req_valid = 1'b1; req_port = port; req_op = op; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 ready low while busy", b_rdy, 0);
    nrsp = 0;
    while (!b_rdy) begin
      if (b_rv) begin
        if (nrsp < 2) begin
          r_port[nrsp] = b_rp; r_store[nrsp] = b_rs; r_ph[nrsp] = b_ph;
          r_st[nrsp] = b_st; r_ad[nrsp] = b_ad; r_vic[nrsp] = b_vic;
          r_ins[nrsp] = b_ins; r_mig[nrsp] = b_mig;
        end
        nrsp++;
      end
      @(negedge clk);
    end
    chk("R10 R7 result pulse count", 64'(nrsp), 64'(nexp));
  endtask

  task automatic expect_rsp(input string tag, input int i, input logic port, input logic [1:0] st,
                            input logic [AW-1:0] vic, ins, input logic ph, input logic [AW-1:0] mig);
    chk({tag, " port"},   r_port[i], port);
    chk({tag, " status"}, r_st[i], st);
    chk({tag, " victim"}, r_vic[i], vic);
    chk({tag, " insert"}, r_ins[i], ins);
    chk({tag, " peer"},   r_ph[i], ph);
    chk({tag, " mig"},    r_mig[i], mig);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R9 ready after reset", b_rdy, 1);
    chk("R9 no pulse after reset", b_rv, 0);
    chk("R9 err after reset", b_err, 0);
    counts("R9", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_sample;
    do_reset(1'b0);
    access(1'b0, 2'd0, 32'h1000, 1);
    expect_rsp("R3 a1", 0, 1'b0, 2'd0, 32'h0, 32'h1000, 1'b0, 32'h0);
    chk("R1 addr echo", r_ad[0], 32'h1000);
    access(1'b1, 2'd0, 32'h1200, 1);
    expect_rsp("R1 a2", 0, 1'b1, 2'd0, 32'h0, 32'h1200, 1'b0, 32'h0);
    access(1'b0, 2'd0, 32'h1202, 1);
    expect_rsp("R4 R5 a3", 0, 1'b0, 2'd2, 32'h1000, 32'h1200, 1'b1, 32'h1200);
    access(1'b1, 2'd0, 32'h1002, 1);
    expect_rsp("R5 dropped victim a4", 0, 1'b1, 2'd0, 32'h0, 32'h1000, 1'b0, 32'h0);
    access(1'b0, 2'd0, 32'h2000, 1);
    expect_rsp("R5 a5", 0, 1'b0, 2'd2, 32'h1200, 32'h2000, 1'b0, 32'h0);
    counts("R11", 0, 3, 2, 1, 2, 0);
    chk("R8 no violation", b_err, 0);
  endtask

  task automatic t_local_hit;
    do_reset(1'b0);
    access(1'b0, 2'd0, 32'h40, 1);
    access(1'b0, 2'd1, 32'h44, 1);
    expect_rsp("R2 store hit", 0, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 32'h0);
    chk("R7 store flag", r_store[0], 1);
    counts("R2 peer untouched", 1, 1, 0, 0, 0, 0);
    access(1'b1, 2'd0, 32'h48, 1);
    expect_rsp("R1 R4 other side", 0, 1'b1, 2'd0, 32'h0, 32'h40, 1'b1, 32'h40);
    chk("R7 load flag", r_store[0], 0);
    counts("R4 peer hit counted", 2, 1, 0, 0, 1, 0);
    chk("R8 no violation", b_err, 0);
  endtask

  task automatic t_lru;
    do_reset(1'b1);
    for (int k = 0; k < 4; k++) begin
      access(1'b0, 2'd0, 32'(k * 32), 1);
      expect_rsp("R6 free way fill", 0, 1'b0, 2'd0, 32'h0, 32'(k * 32), 1'b0, 32'h0);
    end
    access(1'b0, 2'd0, 32'h10, 1);
    expect_rsp("R6 other set", 0, 1'b0, 2'd0, 32'h0, 32'h10, 1'b0, 32'h0);
    access(1'b0, 2'd0, 32'h0, 1);
    expect_rsp("R6 hit reorders", 0, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 32'h0);
    access(1'b0, 2'd0, 32'h80, 1);
    expect_rsp("R6 lru victim", 0, 1'b0, 2'd2, 32'h20, 32'h80, 1'b0, 32'h0);
    access(1'b0, 2'd0, 32'h20, 1);
    expect_rsp("R6 next lru victim", 0, 1'b0, 2'd2, 32'h40, 32'h20, 1'b0, 32'h0);
    counts("R6", 1, 7, 2, 0, 0, 0);
  endtask

  task automatic t_modify;
    do_reset(1'b1);
    access(1'b1, 2'd0, 32'h300, 1);
    access(1'b0, 2'd2, 32'h304, 2);
    expect_rsp("R7 R4 load phase", 0, 1'b0, 2'd0, 32'h0, 32'h300, 1'b1, 32'h300);
    chk("R7 load phase first", r_store[0], 0);
    expect_rsp("R7 store phase", 1, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 32'h0);
    chk("R7 store phase second", r_store[1], 1);
    chk("R7 same address", r_ad[1], 32'h304);
    access(1'b1, 2'd0, 32'h308, 1);
    expect_rsp("R4 migrate back", 0, 1'b1, 2'd0, 32'h0, 32'h300, 1'b1, 32'h300);
    counts("R7", 2, 1, 0, 1, 2, 0);
    chk("R8 no violation", b_err, 0);
  endtask

  initial begin
    t_reset();
    t_sample();
    t_local_hit();
    t_lru();
    t_modify();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule